// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

A single-port synchronous memory in which every command is registered on the rising clock edge. A command consists of the address, active-low chip enable, active-low write enable and four active-low byte-lane selects. A read command's data is loaded into an output register on the edge after the command and is shown for the whole following cycle. Write data lags its address by one cycle. The data-in bus is sampled on the edge after the write command, and the merge into the array happens on that same edge.

The data bus is split into separate data-in and data-out buses plus a drive-enable flag. The drive-enable flag is what a pad ring would use to turn the bus around. It is gated asynchronously by an active-low output enable. It is also held off by three internal rules: while a write's data occupies the bus, while the output slot belongs to a deselected or ignored command, and while the sleep input is high. Sleep stops new commands from being accepted and keeps the stored contents. The array itself has no reset. Only the command pipeline and the output-valid flag are cleared by reset.

Top module: `lwsram`

## Requirements
- R1: A write command (ce_n=0, we_n=0, sleep=0 at edge N) stores the value on din sampled at edge N+1 into the address sampled at edge N.
- R2: A read command (ce_n=0, we_n=1, sleep=0 at edge N) loads the addressed contents onto dout at edge N+1. dout_en is high during the cycle after edge N+1 when oe_n is low, sleep is low and the command at edge N+1 is not a write.
- R3: Byte-lane select bw_n[i]=0 enables lane i, which is bits 9*i+8 down to 9*i. Lanes whose select is high keep their old contents, and a write with every select high changes nothing.
- R4: In the cycle after an edge that samples a write command, dout_en is low whatever oe_n is, because that cycle is the write's data phase.
- R5: A command with ce_n=1 starts nothing and writes nothing, and dout_en is low in the cycle that follows the next edge (its output slot), including when the next command emerges from deselect.
- R6: oe_n high forces dout_en low immediately, without waiting for a clock edge.
- R7: While sleep is high, commands are ignored, dout_en is low and stored contents are preserved. Operation resumes with the first command sampled with sleep low.
- R8: After reset, dout_en is low and no write is pending.
- R9: A read issued at the edge right after a write command to the same address returns the newly merged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands sampled on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the control pipeline |
| sleep | input | 1 | Active-high sleep; ignores commands, holds contents |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable; high selects a read |
| bw_n | input | LANES (4) | Active-low byte-lane write selects |
| addr | input | ADDR_W (6) | Word address |
| din | input | LANES*LANE_W (36) | Write data, sampled one edge after its address |
| oe_n | input | 1 | Active-low asynchronous output enable |
| dout | output | LANES*LANE_W (36) | Registered read data |
| dout_en | output | 1 | Output drive enable for the data bus |

## Verification
The bench issues a write immediately followed by a read of the same address. A design that read the array before merging the late data would return the stale word there. It puts a write right after a read and expects the read's output slot to go undriven. A design that ignored the data-phase mask would show drive-enable high on a bus the host is driving. The bench also sends deselected commands with write enable low and commands during sleep, then reads those addresses back. A design that let either kind of command through would return corrupted words or enable the drive while sleeping. Partial byte-lane writes, including an all-high select pattern, expose lane mapping errors as wrong 9-bit fields in later reads.

// File: rtl/lwsram.sv
module lwsram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic [DATA_W-1:0] mem [DEPTH];

  logic              s1_v, s1_wr, q_v;
  logic [ADDR_W-1:0] s1_a;
  logic [LANES-1:0]  s1_bw;
  logic [DATA_W-1:0] q;

  wire take   = !ce_n && !sleep;
  wire mem_we = s1_v && s1_wr;
  wire rd_hit = s1_v && !s1_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_wr <= 1'b0;
      q_v   <= 1'b0;
    end else begin
      s1_v  <= take;
      s1_wr <= take && !we_n;
      q_v   <= rd_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      s1_a  <= addr;
      s1_bw <= bw_n;
    end
    if (rd_hit) q <= mem[s1_a];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (mem_we && !s1_bw[i])
        mem[s1_a][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  assign dout    = q;
  assign dout_en = !oe_n && !sleep && q_v && !mem_we;

  p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  p_wr_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n && !sleep) |=> !dout_en);

  p_desel_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || sleep) |-> ##2 !dout_en);

  p_desel_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || sleep) |=> !mem_we);

  p_sleep_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

endmodule

// File: tb/lwsram_bench.sv
module lwsram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [3:0]  bw_n = 4'hF;
  logic [5:0]  addr = '0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dout_en;

  always #5 clk = ~clk;

  lwsram u_lwsram (.clk, .rst_n, .sleep, .ce_n, .we_n, .bw_n, .addr, .din,
                   .oe_n, .dout, .dout_en);

  typedef struct { logic en; logic [35:0] d; string tag; } exp_t;
  exp_t exp_q[$];

  int compared = 0, mismatched = 0;
  bit finished = 0;
  string cur_tag = "R8";

  logic [35:0] refm [64];
  logic m_s1v = 0, m_s1wr = 0, m_qv = 0;
  logic [5:0] m_s1a = '0;
  logic [3:0] m_s1bw = 4'hF;
  logic [35:0] m_q = '0;

  function automatic logic [35:0] pat(input int i);
    return 36'(i) * 36'h2_4924_9249 + 36'h1A5;
  endfunction

  task automatic cyc(input logic c, input logic w, input logic [3:0] b,
                     input logic [5:0] a, input logic [35:0] d,
                     input logic oe, input logic slp);
    exp_t e;
    @(negedge clk);
    ce_n = c; we_n = w; bw_n = b; addr = a; din = d; oe_n = oe; sleep = slp;
    @(posedge clk); #1;
    if (m_s1v && !m_s1wr) m_q = refm[m_s1a];
    if (m_s1v && m_s1wr)
      for (int i = 0; i < 4; i++)
        if (!m_s1bw[i]) refm[m_s1a][i*9 +: 9] = d[i*9 +: 9];
    m_qv = m_s1v && !m_s1wr;
    if (!c && !slp) begin
      m_s1v = 1; m_s1wr = !w; m_s1a = a; m_s1bw = b;
    end else m_s1v = 0;
    e.en  = !oe && !slp && m_qv && !(m_s1v && m_s1wr);
    e.d   = m_q;
    e.tag = cur_tag;
    exp_q.push_back(e);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #3;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        compared++;
        if (dout_en !== e.en) begin
          mismatched++;
          $display("FAIL %s: dout_en=%b expected %b", e.tag, dout_en, e.en);
        end else if (e.en && dout !== e.d) begin
          mismatched++;
          $display("FAIL %s: dout=%h expected %h", e.tag, dout, e.d);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #3;
    compared++;
    if (dout_en !== 1'b0) begin
      mismatched++;
      $display("FAIL R8: dout_en=%b expected 0 after reset", dout_en);
    end

    // R1: back-to-back full writes, data lagging address by one cycle
    cur_tag = "R1";
    for (int i = 0; i <= 16; i++)
      cyc(i < 16 ? 1'b0 : 1'b1, 1'b0, 4'h0, 6'(i), i > 0 ? pat(i-1) : 36'h0, 1'b0, 1'b0);

    // R2: back-to-back reads
    cur_tag = "R2";
    for (int i = 0; i < 16; i++) cyc(1'b0, 1'b1, 4'hF, 6'(i), '0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b0, 1'b0);

    // R3: partial lane writes, all-high selects change nothing
    cur_tag = "R3";
    cyc(1'b0, 1'b0, 4'b1010, 6'd3, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 4'b0111, 6'd4, 36'hF_0F0F_0F0F, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 4'b1111, 6'd5, 36'hA_AAAA_AAAA, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd0, 36'h5_5555_5555, 1'b0, 1'b0);
    for (int i = 3; i <= 5; i++) cyc(1'b0, 1'b1, 4'hF, 6'(i), '0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b0, 1'b0);

    // R9: read right after write to same address
    cur_tag = "R9";
    cyc(1'b0, 1'b0, 4'b0000, 6'd7, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 4'hF, 6'd7, 36'h3_C3C3_C3C3, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 4'b1110, 6'd7, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 4'hF, 6'd7, 36'h0_0000_01FF, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b0, 1'b0);

    // R4: read followed by write masks the read's slot
    cur_tag = "R4";
    cyc(1'b0, 1'b1, 4'hF, 6'd1, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 4'h0, 6'd2, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 4'hF, 6'd2, 36'h9_8765_4321, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b0, 1'b0);

    // R5: deselect with write enable low must not write; emerging slot off
    cur_tag = "R5";
    cyc(1'b0, 1'b1, 4'hF, 6'd0, '0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 4'h0, 6'd9, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 4'hF, 6'd9, 36'hB_ADBA_DBAD, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd9, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 4'hF, 6'd9, '0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b0, 1'b0);

    // R6: output enable high blocks drive
    cur_tag = "R6";
    for (int i = 10; i < 13; i++) cyc(1'b0, 1'b1, 4'hF, 6'(i), '0, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 4'hF, 6'd11, '0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b0, 1'b0);

    // R7: sleep ignores commands, blocks drive, holds contents
    cur_tag = "R7";
    cyc(1'b0, 1'b1, 4'hF, 6'd12, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 4'h0, 6'd10, '0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 4'hF, 6'd13, 36'hE_EEEE_EEEE, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 4'h0, 6'd14, 36'hD_DDDD_DDDD, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 4'hF, 6'd10, 36'hC_CCCC_CCCC, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 4'hF, 6'd14, '0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b0, 1'b0);

    repeat (3) @(posedge clk);
    summary();
  end
endmodule